// File: doc/BRIEF.md
# Optical Black Clamp with Per-Color Offset

This block sits at the front of a raw sensor pipeline. Each pixel arrives as an unsigned, LSB-aligned Bayer sample, together with its column and row position, a valid strobe, and a start-of-frame flag. A window of optically masked pixels near the top-left of the frame is summed. The window starts at a programmable column and row and spans a power-of-two number of columns and rows. The mean of that window is scaled by an unsigned gain with four fractional bits. From the next line onward, the scaled value is subtracted from every pixel. Software can instead select a fixed black level, which bypasses the measured value.

A second stage removes a colour-dependent offset. Four offset values are held. A 2x2 map assigns one of them to each pixel, chosen by row parity and column parity. Both subtractions stop at zero. The result leaves the block one clock after the pixel entered.

Top module: `ob_clamp_top`

## Requirements
- R1: `valid_o` and `pix_o` are low/zero after reset. A pixel accepted with `valid_i` high at clock edge k appears on `pix_o` with `valid_o` high after edge k. When `valid_i` is low, `valid_o` is low one cycle later.
- R2: The averaging window covers columns `ob_x_i` to `ob_x_i + 2^ob_pix_log2_i - 1` and rows `ob_y_i` to `ob_y_i + 2^ob_line_log2_i - 1`. Each log2 field takes the values 0 to 4, so a window is 1, 2, 4, 8 or 16 pixels wide and 1, 2, 4, 8 or 16 rows high.
- R3: The window sum is shifted right by `ob_pix_log2_i + ob_line_log2_i`. It is then multiplied by `ob_gain_i`, an unsigned value with 4 fractional bits, so 16 means 1.0. The product is shifted right by 4 and saturated to 2^DW-1. The result becomes the black level from the first pixel of the first line after the window's last pixel.
- R4: With `avg_en_i` low, `dc_level_i` is subtracted in place of the measured black level.
- R5: After the black subtraction, `color_off_i[c]` is subtracted, where c = `color_map_i[2*y[0] + x[0]]` is a 2-bit code.
- R6: Each subtraction saturates at zero, so `pix_o` never exceeds the accepted pixel.
- R7: Until the window of the current frame completes, the black level from the previous frame stays in use. After reset, that level is zero.
- R8: `sof_i` marks the first pixel of a frame. It clears the window sum and counts as a line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Pixel strobe |
| sof_i | input | 1 | First pixel of a frame |
| x_i | input | XW | Column of the pixel |
| y_i | input | YW | Row of the pixel |
| pix_i | input | DW | Raw pixel, LSB aligned |
| avg_en_i | input | 1 | 1: measured black level, 0: constant |
| ob_x_i | input | XW | First column of the window |
| ob_y_i | input | YW | First row of the window |
| ob_pix_log2_i | input | 3 | log2 of window width (0..4) |
| ob_line_log2_i | input | 3 | log2 of window height (0..4) |
| ob_gain_i | input | GW | Gain, 4 fractional bits |
| dc_level_i | input | DW | Constant black level |
| color_off_i | input | 4*DW | Four colour offsets, indexed by code |
| color_map_i | input | 8 | 2-bit code per 2x2 position |
| valid_o | output | 1 | Output strobe |
| pix_o | output | DW | Corrected pixel |

## Verification
The assertions assume the following about the inputs:
- Configuration inputs change only while no frame is in flight.
- Within a frame, rows arrive in increasing order.
- The window fits inside the frame.
- The log2 fields stay in the range 0 to 4.

The stimulus meets these assumptions in three ways. It changes settings only during idle gaps between frames. It raises `sof_i` exactly once, on pixel (0,0). It sizes every frame to contain the window it configures, with idle cycles inserted between lines.

// File: rtl/blk_clamp_pkg.sv
package blk_clamp_pkg;
  localparam int unsigned MAX_LOG2 = 4;
  localparam int unsigned GAIN_FRAC = 4;
  typedef logic [2:0] log2_t;
  typedef logic [1:0] color_code_t;
endpackage

// File: rtl/sat_sub.sv
module sat_sub #(
  parameter int unsigned DW = 12
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] d_o
);
  always_comb begin
    d_o = (a_i > b_i) ? (a_i - b_i) : '0;
    // R6
    no_wrap_chk: assert (d_o <= a_i);
  end
endmodule

// File: rtl/ob_avg.sv
module ob_avg
  import blk_clamp_pkg::*;
#(
  parameter int unsigned DW = 12,
  parameter int unsigned XW = 12,
  parameter int unsigned YW = 12,
  parameter int unsigned GW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sof_i,
  input  logic [XW-1:0] x_i,
  input  logic [YW-1:0] y_i,
  input  logic [DW-1:0] pix_i,
  input  logic [XW-1:0] ob_x_i,
  input  logic [YW-1:0] ob_y_i,
  input  log2_t         pix_log2_i,
  input  log2_t         line_log2_i,
  input  logic [GW-1:0] gain_i,
  output logic [DW-1:0] black_o
);
  localparam int unsigned SW = DW + 2 * MAX_LOG2;
  localparam int unsigned PW = DW + GW;

  logic [SW-1:0] acc_q, acc_base, acc_nxt;
  logic [DW-1:0] pend_q, act_q, black_new;
  logic          pend_f_q;
  logic [YW-1:0] last_y_q;
  logic [XW:0]   x_end;
  logic [YW:0]   y_end;
  logic          in_x, in_y, in_win, done, line_new, commit;
  logic [3:0]    shamt;
  logic [SW-1:0] avg_full;
  logic [PW-1:0] prod, scaled;

  assign x_end  = {1'b0, ob_x_i} + ((XW+1)'(1) << pix_log2_i);
  assign y_end  = {1'b0, ob_y_i} + ((YW+1)'(1) << line_log2_i);
  assign in_x   = (x_i >= ob_x_i) && ({1'b0, x_i} < x_end);
  assign in_y   = (y_i >= ob_y_i) && ({1'b0, y_i} < y_end);
  assign in_win = valid_i && in_x && in_y;
  assign done   = in_win && ({1'b0, x_i} == x_end - 1'b1) && ({1'b0, y_i} == y_end - 1'b1);

  assign acc_base = sof_i ? '0 : acc_q;
  assign acc_nxt  = acc_base + (in_win ? SW'(pix_i) : '0);

  assign shamt    = {1'b0, pix_log2_i} + {1'b0, line_log2_i};
  assign avg_full = acc_nxt >> shamt;
  assign prod     = PW'(avg_full[DW-1:0]) * PW'(gain_i);
  assign scaled   = prod >> GAIN_FRAC;
  assign black_new = (|scaled[PW-1:DW]) ? '1 : scaled[DW-1:0];

  assign line_new = valid_i && (sof_i || (y_i != last_y_q));
  assign commit   = line_new && pend_f_q;
  assign black_o  = commit ? pend_q : act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      pend_q   <= '0;
      act_q    <= '0;
      pend_f_q <= 1'b0;
      last_y_q <= '0;
    end else if (valid_i) begin
      acc_q    <= acc_nxt;
      last_y_q <= y_i;
      if (commit) begin
        act_q    <= pend_q;
        pend_f_q <= 1'b0;
      end
      if (done) begin
        pend_q   <= black_new;
        pend_f_q <= 1'b1;
      end
    end
  end

  // R3
  no_mid_line_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sof_i && (y_i == last_y_q)) |=> $stable(act_q));

  // R8
  sof_clears_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sof_i && !in_win) |=> (acc_q == '0));
endmodule

// File: rtl/cfa_offset.sv
module cfa_offset
  import blk_clamp_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic                  x_lsb_i,
  input  logic                  y_lsb_i,
  input  logic [DW-1:0]         din_i,
  input  logic [3:0][DW-1:0]    off_i,
  input  logic [3:0][1:0]       map_i,
  output logic [DW-1:0]         dout_o
);
  color_code_t   code;
  logic [DW-1:0] off_sel;

  assign code    = map_i[{y_lsb_i, x_lsb_i}];
  assign off_sel = off_i[code];

  sat_sub #(.DW(DW)) i_sub (
    .a_i (din_i),
    .b_i (off_sel),
    .d_o (dout_o)
  );
endmodule

// File: rtl/ob_clamp_top.sv
module ob_clamp_top
  import blk_clamp_pkg::*;
#(
  parameter int unsigned DW = 12,
  parameter int unsigned XW = 12,
  parameter int unsigned YW = 12,
  parameter int unsigned GW = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic                  sof_i,
  input  logic [XW-1:0]         x_i,
  input  logic [YW-1:0]         y_i,
  input  logic [DW-1:0]         pix_i,
  input  logic                  avg_en_i,
  input  logic [XW-1:0]         ob_x_i,
  input  logic [YW-1:0]         ob_y_i,
  input  logic [2:0]            ob_pix_log2_i,
  input  logic [2:0]            ob_line_log2_i,
  input  logic [GW-1:0]         ob_gain_i,
  input  logic [DW-1:0]         dc_level_i,
  input  logic [3:0][DW-1:0]    color_off_i,
  input  logic [3:0][1:0]       color_map_i,
  output logic                  valid_o,
  output logic [DW-1:0]         pix_o
);
  logic [DW-1:0] black_meas, black_sel, clamped, corrected;

  ob_avg #(.DW(DW), .XW(XW), .YW(YW), .GW(GW)) i_ob_avg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .sof_i       (sof_i),
    .x_i         (x_i),
    .y_i         (y_i),
    .pix_i       (pix_i),
    .ob_x_i      (ob_x_i),
    .ob_y_i      (ob_y_i),
    .pix_log2_i  (ob_pix_log2_i),
    .line_log2_i (ob_line_log2_i),
    .gain_i      (ob_gain_i),
    .black_o     (black_meas)
  );

  assign black_sel = avg_en_i ? black_meas : dc_level_i;

  sat_sub #(.DW(DW)) i_clamp (
    .a_i (pix_i),
    .b_i (black_sel),
    .d_o (clamped)
  );

  cfa_offset #(.DW(DW)) i_cfa (
    .x_lsb_i (x_i[0]),
    .y_lsb_i (y_i[0]),
    .din_i   (clamped),
    .off_i   (color_off_i),
    .map_i   (color_map_i),
    .dout_o  (corrected)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pix_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) pix_o <= corrected;
    end
  end

  // R1
  out_follows_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R1
  no_spurious_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R6
  no_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (pix_o <= $past(pix_i)));
  // R6
  zero_stays_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pix_i == '0) |=> (pix_o == '0));
  // R4
  dc_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !avg_en_i && pix_i <= dc_level_i) |=> (pix_o == '0));
endmodule

// File: tb/test_ob_clamp_top.sv
module test_ob_clamp_top;
  localparam int DW = 12, XW = 12, YW = 12, GW = 8;
  localparam int PMAX = (1 << DW) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0, sof_i = 1'b0;
  logic [XW-1:0] x_i = '0;
  logic [YW-1:0] y_i = '0;
  logic [DW-1:0] pix_i = '0;
  logic avg_en = 1'b0;
  logic [XW-1:0] ob_x = '0;
  logic [YW-1:0] ob_y = '0;
  logic [2:0] pl = '0, ll = '0;
  logic [GW-1:0] gain = 8'd16;
  logic [DW-1:0] dc = '0;
  logic [3:0][DW-1:0] offs = '0;
  logic [3:0][1:0] cmap = '0;
  logic valid_o;
  logic [DW-1:0] pix_o;

  int checks = 0, fails = 0;
  int exp_q[$];
  string tag_q[$];
  int m_acc = 0, m_pend = 0, m_act = 0, m_last_y = 0;
  bit m_pend_f = 0;

  always #4 clk = ~clk;

  ob_clamp_top #(.DW(DW), .XW(XW), .YW(YW), .GW(GW)) i_ob_clamp_top (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sof_i(sof_i),
    .x_i(x_i), .y_i(y_i), .pix_i(pix_i), .avg_en_i(avg_en),
    .ob_x_i(ob_x), .ob_y_i(ob_y), .ob_pix_log2_i(pl), .ob_line_log2_i(ll),
    .ob_gain_i(gain), .dc_level_i(dc), .color_off_i(offs), .color_map_i(cmap),
    .valid_o(valid_o), .pix_o(pix_o)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // reference model built from the requirements
  task automatic model_push(int x, int y, bit sof, int pix, string tag);
    int blk, s1, code, s2, pw, lh, b;
    if ((sof || y != m_last_y) && m_pend_f) begin  // R3 line-start commit
      m_act = m_pend;
      m_pend_f = 0;
    end
    blk = avg_en ? m_act : int'(dc);                  // R4 / R7
    s1 = (pix > blk) ? pix - blk : 0;                 // R6
    code = int'(cmap[2*(y%2) + (x%2)]);               // R5
    s2 = (s1 > int'(offs[code])) ? s1 - int'(offs[code]) : 0;
    exp_q.push_back(s2);
    tag_q.push_back(tag);
    pw = 1 << pl;
    lh = 1 << ll;
    if (sof) m_acc = 0;                               // R8
    if (x >= int'(ob_x) && x < int'(ob_x) + pw && y >= int'(ob_y) && y < int'(ob_y) + lh) begin
      m_acc += pix;                                   // R2
      if (x == int'(ob_x) + pw - 1 && y == int'(ob_y) + lh - 1) begin
        b = ((m_acc >> (int'(pl) + int'(ll))) * int'(gain)) >> 4;
        m_pend = (b > PMAX) ? PMAX : b;
        m_pend_f = 1;
      end
    end
    m_last_y = y;
  endtask

  task automatic drive(int x, int y, bit sof, int pix, string tag);
    @(negedge clk);
    valid_i = 1'b1; sof_i = sof;
    x_i = XW'(x); y_i = YW'(y); pix_i = DW'(pix);
    model_push(x, y, sof, pix, tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0; sof_i = 1'b0;
    end
  endtask

  task automatic frame(int w, int h, int lo, int hi, string tag);
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++)
        drive(x, y, (x == 0 && y == 0), int'($urandom_range(hi, lo)), tag);
      idle(y % 3);
    end
    idle(4);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) check(1'b0, "R1 unexpected output", int'(pix_o), -1);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(pix_o) == e, t, int'(pix_o), e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R1 reset valid", int'(valid_o), 0);
    check(pix_o == '0, "R1 reset pixel", int'(pix_o), 0);
    rst_ni = 1'b1;
    idle(2);

    // constant black level with distinct colour offsets
    avg_en = 0; dc = 12'd50;
    offs = {12'd40, 12'd30, 12'd20, 12'd10};
    cmap = {2'd3, 2'd2, 2'd1, 2'd0};
    frame(8, 4, 100, 4095, "R4 R5 const+offset");

    // permuted map, low pixels force zero saturation
    cmap = {2'd0, 2'd2, 2'd1, 2'd3};
    frame(8, 4, 0, 120, "R5 R6 permuted map/saturation");

    // measured black: window 4x2 at (2,1), unity gain, zero offsets
    offs = '0; avg_en = 1; ob_x = 12'd2; ob_y = 12'd1; pl = 3'd2; ll = 3'd1; gain = 8'd16;
    frame(12, 6, 100, 600, "R2 R3 R7 R8 window 4x2 gain 1.0");
    gain = 8'd24;
    frame(12, 6, 100, 600, "R3 R7 carry prev frame, gain 1.5");

    // single-sample window at origin
    ob_x = '0; ob_y = '0; pl = 3'd0; ll = 3'd0; gain = 8'd16;
    frame(6, 3, 0, 4095, "R2 R3 R8 1x1 window");

    // huge gain saturates black level
    gain = 8'd255;
    frame(6, 3, 2000, 4095, "R3 R6 gain saturation");

    // full 16x16 window
    ob_x = 12'd1; pl = 3'd4; ll = 3'd4; gain = 8'd20;
    offs = {12'd7, 12'd5, 12'd3, 12'd1};
    frame(20, 18, 50, 400, "R2 R3 R5 16x16 window");

    idle(3);
    check(exp_q.size() == 0, "R1 outputs missing", exp_q.size(), 0);
    summary();
  end
endmodule